// File: doc/BRIEF.md
# Pulse Period and High-Time Meter

This block measures an external pulse train on a single input pin. A free-running tick counter, cleared at the start of each measurement, is sampled by two capture registers that both watch the same synchronised pin: one latches the count on rising edges and the other on falling edges. Each rising-edge capture takes a snapshot of both registers. The first snapshot supplies the reference rise time. The second supplies the next rise time and the latest fall time. From these three values the block computes the period and the high time in counter ticks.

The arithmetic corrects for counter wrap. It also corrects the case where a newer falling edge overwrites the fall register before the snapshot is taken, since the snapshot is read two cycles after the rising capture. An edge divider can make both capture registers fire on only every 2nd, 4th or 8th edge of their polarity, which averages the period over several cycles and needs its own high-time correction. A start pulse begins a run. If the second snapshot does not arrive within a programmed number of clocks, the run ends with a timeout flag instead of a result.

The control state machine has five states:
- `ST_IDLE` is the state after reset.
- `ST_ARM` waits for the first snapshot.
- `ST_HALF` waits for the second snapshot.
- `ST_DONE` holds a result.
- `ST_EXPIRED` holds a timeout.

Its transitions are:
- start: from any state to `ST_ARM`.
- first snapshot: `ST_ARM` to `ST_HALF`.
- second snapshot: `ST_HALF` to `ST_DONE`.
- window expiry: `ST_ARM` or `ST_HALF` to `ST_EXPIRED`.

In `ST_ARM` the window expiry takes priority over a snapshot. In `ST_HALF` a snapshot takes priority over the window expiry.

Top module: `pwm_pulse_meter`

## Requirements
- R1: With the edge divider at 1 and both capture units in use, `period` equals the ticks between two consecutive rising edges and `duty` equals the ticks from the first of those rises to the following fall.
- R2: The tick counter advances once every `cfg_clk_div`+1 clocks, and both results are expressed in those ticks.
- R3: A `start` pulse clears the counter, the captures and the edge dividers. In the next cycle `busy` is 1 and both `done` and `timeout` are 0.
- R4: When a later capture value is smaller than the earlier one, the difference is taken as MAX minus earlier plus later, where MAX = 2^CNT_W-1. This is one tick less than the true span.
- R5: If the computed high time exceeds the computed period, the period is subtracted from the high time.
- R6: `cfg_edge_div` values 0, 1, 2 and 3 make each capture unit fire on the 1st qualifying edge after start and then on every 1st, 2nd, 4th or 8th edge. The reported period is the raw rise-to-rise difference shifted right by `cfg_edge_div`.
- R7: When `cfg_edge_div` is non-zero and the raw high time is at least the shifted period, `duty` becomes the shifted period minus (raw period minus raw high time).
- R8: With `cfg_dual` = 0 (falling-edge unit unused), the reported `duty` is 0.
- R9: If the second snapshot has not arrived within `cfg_timeout` clocks after start, `timeout` rises, `busy` and `done` fall, and no result is reported.
- R10: After `done` rises, it stays 1 and `period` and `duty` stay unchanged until the next `start`, whatever the pin does.
- R11: After reset, `busy`, `done`, `timeout`, `period` and `duty` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that clears and starts a measurement |
| cfg_clk_div | input | DIV_W | Tick counter advances every cfg_clk_div+1 clocks |
| cfg_edge_div | input | 2 | Edge divider select: 0..3 for every 1, 2, 4, 8 edges |
| cfg_dual | input | 1 | 1 = falling-edge unit used for the high time |
| cfg_timeout | input | TO_W | Clocks allowed from start to the second snapshot |
| pin_in | input | 1 | Asynchronous pulse input |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Result valid, held until next start |
| timeout | output | 1 | Run expired without result, held until next start |
| period | output | CNT_W | Measured period in ticks |
| duty | output | CNT_W | Measured high time in ticks |

## Verification
A wrong state register shows at the ports within one cycle of the faulty transition. Either `busy` stays high past the timeout window, or `done` rises without the matching period, or `done` drops while the pin toggles. A mis-timed capture or a broken edge divider shows only when `done` rises, as a `period` or `duty` that is off by whole ticks or by a factor of two. The bench therefore compares every result against values derived from the pulse timing it drove. It covers patterns that wrap the counter, that fire the race correction, and that begin with the pin high.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_HALF,
        ST_DONE,
        ST_EXPIRED
    } pcap_state_e;
endpackage

// File: rtl/pcap_timebase.sv
module pcap_timebase #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] count
);
    logic [DIV_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            count <= '0;
        end else if (clear) begin
            pre_q <= '0;
            count <= '0;
        end else if (run) begin
            if (pre_q >= div) begin
                pre_q <= '0;
                count <= count + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcap_edge.sv
module pcap_edge #(
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             pin,
    input  logic [SEL_W-1:0] sel,
    output logic             rise_evt,
    output logic             fall_evt
);
    localparam int NW = (1 << SEL_W) - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;
    logic [1:0]             raw;
    logic [1:0]             evt;
    logic [NW-1:0]          mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level  = sync_q[SYNC_STAGES-1];
    assign raw[0] = level & ~prev_q;
    assign raw[1] = ~level & prev_q;
    assign mask   = NW'((32'd1 << sel) - 32'd1);

    // one divider per edge polarity: index 0 rising, index 1 falling
    for (genvar g = 0; g < 2; g++) begin : g_pol
        logic [NW-1:0] n_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                n_q <= '0;
            end else if (clear) begin
                n_q <= '0;
            end else if (enable && raw[g]) begin
                n_q <= (n_q + 1'b1) & mask;
            end
        end
        assign evt[g] = enable && raw[g] && (n_q == '0);
    end

    assign rise_evt = evt[0];
    assign fall_evt = evt[1];
endmodule

// File: rtl/pcap_calc.sv
module pcap_calc #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] t0,
    input  logic [CNT_W-1:0] t1,
    input  logic [CNT_W-1:0] t2,
    input  logic [1:0]       sel,
    input  logic             dual,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] duty
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
        if (a <= b) return b - a;
        return CNT_MAX - a + b;
    endfunction

    logic [CNT_W-1:0] praw, draw, pshift;

    always_comb begin
        praw   = span(t0, t2);
        draw   = dual ? span(t0, t1) : '0;
        if (draw > praw) draw = draw - praw;
        pshift = praw >> sel;
        duty   = draw;
        if (dual && (sel != 2'd0) && (draw >= pshift))
            duty = pshift - (praw - draw);
        period = pshift;
    end
endmodule

// File: rtl/pwm_pulse_meter.sv
module pwm_pulse_meter
    import pcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 16,
    parameter int TO_W        = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] cfg_clk_div,
    input  logic [1:0]       cfg_edge_div,
    input  logic             cfg_dual,
    input  logic [TO_W-1:0]  cfg_timeout,
    input  logic             pin_in,
    output logic             busy,
    output logic             done,
    output logic             timeout,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] duty
);
    pcap_state_e      state_q, state_d;
    logic             running;
    logic             rise_evt, fall_evt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_a_q, cap_b_q, t0_q;
    logic [1:0]       snap_q;
    logic             snap_now;
    logic [TO_W-1:0]  wait_q;
    logic             timed_out;
    logic [CNT_W-1:0] calc_period, calc_duty;

    assign running   = (state_q == ST_ARM) || (state_q == ST_HALF);
    assign snap_now  = snap_q[1];
    assign timed_out = running && (wait_q >= cfg_timeout);

    pcap_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .clear(start), .run(running),
        .div(cfg_clk_div), .count(cnt)
    );

    pcap_edge #(.SYNC_STAGES(SYNC_STAGES), .SEL_W(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .clear(start), .enable(running),
        .pin(pin_in), .sel(cfg_edge_div),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    pcap_calc #(.CNT_W(CNT_W)) u_calc (
        .t0(t0_q), .t1(cap_b_q), .t2(cap_a_q),
        .sel(cfg_edge_div), .dual(cfg_dual),
        .period(calc_period), .duty(calc_duty)
    );

    // capture units, snapshot delay and window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a_q <= '0;
            cap_b_q <= '0;
            snap_q  <= '0;
            wait_q  <= '0;
        end else if (start) begin
            cap_a_q <= '0;
            cap_b_q <= '0;
            snap_q  <= '0;
            wait_q  <= '0;
        end else begin
            if (rise_evt) cap_a_q <= cnt;
            if (fall_evt) cap_b_q <= cnt;
            snap_q <= {snap_q[0], rise_evt};
            if (running) wait_q <= wait_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_EXPIRED: begin
                if (start) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (start)          state_d = ST_ARM;
                else if (timed_out) state_d = ST_EXPIRED;
                else if (snap_now)  state_d = ST_HALF;
            end
            ST_HALF: begin
                if (start)          state_d = ST_ARM;
                else if (snap_now)  state_d = ST_DONE;
                else if (timed_out) state_d = ST_EXPIRED;
            end
        endcase
    end

    // snapshot and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t0_q   <= '0;
            period <= '0;
            duty   <= '0;
        end else if (start) begin
            t0_q   <= '0;
            period <= '0;
            duty   <= '0;
        end else begin
            if (state_q == ST_ARM && state_d == ST_HALF) t0_q <= cap_a_q;
            if (state_q == ST_HALF && state_d == ST_DONE) begin
                period <= calc_period;
                duty   <= calc_duty;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = running;
        done    = (state_q == ST_DONE);
        timeout = (state_q == ST_EXPIRED);
    end
endmodule

// File: rtl/pcap_checker.sv
module pcap_checker #(
    parameter int CNT_W = 16,
    parameter int TO_W  = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cfg_dual,
    input logic [TO_W-1:0]  cfg_timeout,
    input logic             busy,
    input logic             done,
    input logic             timeout,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] duty
);
    logic [TO_W:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cyc_q <= '0;
        else if (start) cyc_q <= '0;
        else if (busy)  cyc_q <= cyc_q + 1'b1;
    end

    assert_start_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done && !timeout));

    assert_single_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !cfg_dual) |-> (duty == '0));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(period) && $stable(duty)));

    assert_window_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cyc_q <= {1'b0, cfg_timeout}));

    assert_expire_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (!done && $past(busy)));
endmodule

bind pwm_pulse_meter pcap_checker #(.CNT_W(CNT_W), .TO_W(TO_W)) u_pcap_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dual(cfg_dual),
    .cfg_timeout(cfg_timeout), .busy(busy), .done(done), .timeout(timeout),
    .period(period), .duty(duty)
);

// File: tb/tb_pwm_pulse_meter.sv
module tb_pwm_pulse_meter;
    localparam int CNT_W = 8;
    localparam int DIV_W = 8;
    localparam int TO_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [DIV_W-1:0] cfg_clk_div = '0;
    logic [1:0]       cfg_edge_div = '0;
    logic             cfg_dual = 1'b1;
    logic [TO_W-1:0]  cfg_timeout = 16'd2000;
    logic             pin_in = 1'b0;
    logic             busy, done, timeout;
    logic [CNT_W-1:0] period, duty;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    typedef struct {
        bit    is_to;
        int    p;
        int    d;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    pwm_pulse_meter #(.CNT_W(CNT_W), .DIV_W(DIV_W), .TO_W(TO_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_clk_div(cfg_clk_div),
        .cfg_edge_div(cfg_edge_div), .cfg_dual(cfg_dual), .cfg_timeout(cfg_timeout),
        .pin_in(pin_in), .busy(busy), .done(done), .timeout(timeout),
        .period(period), .duty(duty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input bit is_to, input int p, input int d, input string tag);
        exp_t e;
        e.is_to = is_to; e.p = p; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic hold(input bit v, input int c);
        pin_in = v;
        repeat (c) @(negedge clk);
    endtask

    task automatic arm(input int d, input int es, input bit du, input bit init, input int to);
        pin_in = init;
        repeat (4) @(negedge clk);
        cfg_clk_div  = DIV_W'(d);
        cfg_edge_div = 2'(es);
        cfg_dual     = du;
        cfg_timeout  = TO_W'(to);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        chk(done == 1'b0, "R3 done after start", int'(done), 0);
        chk(timeout == 1'b0, "R3 timeout after start", int'(timeout), 0);
    endtask

    task automatic wait_drain(input string tag);
        for (int i = 0; i < 4000 && sb.size() != 0; i++) @(negedge clk);
        chk(sb.size() == 0, tag, sb.size(), 0);
    endtask

    task automatic train(input int hi, input int lo, input int n);
        for (int i = 0; i < n; i++) begin
            hold(1'b1, hi);
            hold(1'b0, lo);
        end
    endtask

    // monitor: pops one expected item per completed run
    initial begin
        bit done_prev = 0;
        bit to_prev = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if ((done && !done_prev) || (timeout && !to_prev)) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "unexpected completion", int'(done), 0);
                end else begin
                    e = sb.pop_front();
                    if (e.is_to) begin
                        chk(timeout && !done && !busy, e.tag, int'(timeout), 1);
                    end else begin
                        chk(done == 1'b1, e.tag, int'(done), 1);
                        chk(int'(period) == e.p, {e.tag, " period"}, int'(period), e.p);
                        chk(int'(duty) == e.d, {e.tag, " duty"}, int'(duty), e.d);
                    end
                end
            end
            done_prev = done;
            to_prev = timeout;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 0, "R11 busy", int'(busy), 0);
        chk(done == 0, "R11 done", int'(done), 0);
        chk(timeout == 0, "R11 timeout", int'(timeout), 0);
        chk(period == 0, "R11 period", int'(period), 0);
        chk(duty == 0, "R11 duty", int'(duty), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 basic
        push(0, 80, 30, "R1 80/30");
        arm(0, 0, 1, 0, 2000);
        hold(0, 5); train(30, 50, 4);
        wait_drain("R1 drain a");

        push(0, 100, 10, "R1 100/10");
        arm(0, 0, 1, 0, 2000);
        hold(0, 5); train(10, 90, 3);
        wait_drain("R1 drain b");

        // R10 result held while pin keeps toggling
        train(7, 13, 4);
        chk(done == 1, "R10 done held", int'(done), 1);
        chk(period == 100, "R10 period held", int'(period), 100);
        chk(duty == 10, "R10 duty held", int'(duty), 10);

        // R2 tick divider (every 4 clocks)
        push(0, 20, 5, "R2 div4");
        arm(3, 0, 1, 0, 2000);
        hold(0, 5); train(20, 60, 3);
        wait_drain("R2 drain");

        // R8 single capture unit
        push(0, 80, 0, "R8 single unit");
        arm(0, 0, 0, 0, 2000);
        hold(0, 5); train(30, 50, 3);
        wait_drain("R8 drain");

        // R4 counter wrap: true span 200 reported as 199
        push(0, 199, 50, "R4 wrap");
        arm(0, 0, 1, 0, 2000);
        hold(0, 100); train(50, 150, 3);
        wait_drain("R4 drain");

        // R5 race: fall one clock after second rise
        push(0, 80, 1, "R5 race");
        arm(0, 0, 1, 0, 2000);
        hold(0, 5); hold(1, 30); hold(0, 50); hold(1, 1); hold(0, 40);
        wait_drain("R5 drain");

        // R6 edge divider 2 and 8
        push(0, 40, 12, "R6 div2");
        arm(0, 1, 1, 0, 2000);
        hold(0, 5); train(12, 28, 4);
        wait_drain("R6 drain a");

        push(0, 25, 10, "R6 div8");
        arm(0, 3, 1, 0, 2000);
        hold(0, 5); train(10, 15, 10);
        wait_drain("R6 drain b");

        // R7 divider 4, pin high at start: raw duty 135 corrected to 15
        push(0, 40, 15, "R7 div4 high start");
        arm(0, 2, 1, 1, 2000);
        hold(1, 5); train(15, 25, 6);
        wait_drain("R7 drain");

        // R9 timeout with static pin
        push(1, 0, 0, "R9 timeout");
        arm(0, 0, 1, 0, 300);
        hold(0, 400);
        wait_drain("R9 drain");
        chk(busy == 0, "R9 busy low", int'(busy), 0);
        chk(done == 0, "R9 no result", int'(done), 0);
        chk(timeout == 1, "R9 timeout held", int'(timeout), 1);

        // R3 restart clears the timeout flag
        arm(0, 0, 1, 0, 2000);
        chk(timeout == 0, "R3 timeout cleared", int'(timeout), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule